// File: doc/BRIEF.md
# Dual-Issue Warp Instruction Scheduler

This block picks instructions to issue for a streaming multiprocessor. It holds up to 48 resident warps. Each warp has one buffered instruction slot, and those slots are filled from a single shared decoded-instruction stream. On every scheduler cycle the block may issue up to two instructions from two different warps. The first goes to sub-block A, the 16-lane half that can also run double-precision work. The second goes to sub-block B, the 16-lane half that feeds the special-function unit. Each sub-block needs two fast clocks per warp instruction, so one issue per sub-block per scheduler cycle keeps both halves busy.

A per-warp scoreboard marks destination registers as pending from the moment of issue. Register writeback pulses clear those marks, and so do memory-return pulses. A warp that issues a memory instruction is parked until its data comes back, so it holds no execution slot in the meantime. Structural hazards are enforced as follows. A double-precision issue takes every operand port, which keeps sub-block B idle in the same cycle and both sub-blocks idle for the rest of its hold time. The special-function unit accepts a new warp only after a fixed recovery gap. Among ready warps, a round-robin pointer decides who goes first. The stall output tells the instruction source that the addressed warp's slot is still full.

Top module: `wsched_top`

## Requirements
- R1: While reset is high and after it is released, no issue is reported on either sub-block and stall is low; all slots, scoreboard marks, parking, pointer and hazard counters start cleared (pointer at warp 0).
- R2: An input with in_valid high is stored into the slot of in_warp at the clock edge when that slot is empty. stall is high in the same cycle, combinationally, whenever in_valid is high and that slot is full, and the offered instruction is then dropped. A slot empties at the edge where its instruction issues.
- R3: At most two instructions issue per cycle, and when both sub-blocks issue they carry different warps.
- R4: Sub-block A takes the first eligible warp, counting from the round-robin pointer upward and wrapping at 48, whose class is not special-function. Sub-block B takes the first eligible warp in the same order, other than A's warp, that it may accept. After any issue, the pointer moves to one past whichever issued warp lies later in that order.
- R5: Class encoding is 0 integer/float ALU, 1 double-precision, 2 special-function, 3 memory. Double-precision goes only to A, special-function only to B, and ALU and memory to either.
- R6: In a cycle where A issues double-precision, B issues nothing. For the next DP_HOLD-1 cycles (1 by default) neither sub-block issues.
- R7: After a special-function issue on B, the next special-function issue comes no sooner than SFU_GAP (8) cycles later.
- R8: Issue marks the warp's destination register pending. A warp is eligible only when neither source register nor its destination register is pending. A writeback pulse (warp, register) clears that mark.
- R9: A memory-class issue parks its warp, and a parked warp does not issue. A memory-return pulse (warp, register) clears that register's mark and unparks the warp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scheduler clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decoded instruction offered |
| in_warp | input | 6 | Warp that owns the offered instruction |
| in_cls | input | 2 | Instruction class (R5 encoding) |
| in_dst | input | 4 | Destination register |
| in_src0 | input | 4 | First source register |
| in_src1 | input | 4 | Second source register |
| stall | output | 1 | Offered instruction refused, slot full |
| wb_valid | input | 1 | Register writeback pulse |
| wb_warp | input | 6 | Warp of the writeback |
| wb_reg | input | 4 | Register written back |
| mem_valid | input | 1 | Memory return pulse |
| mem_warp | input | 6 | Warp whose data returned |
| mem_reg | input | 4 | Register filled by the return |
| a_valid | output | 1 | Issue to sub-block A |
| a_warp | output | 6 | Warp issued to A |
| a_cls | output | 2 | Class issued to A |
| a_dst | output | 4 | Destination of A's instruction |
| b_valid | output | 1 | Issue to sub-block B |
| b_warp | output | 6 | Warp issued to B |
| b_cls | output | 2 | Class issued to B |
| b_dst | output | 4 | Destination of B's instruction |

## Verification
The bench targets four corner cases.

- A double-precision issue followed by two ALU warps. A design that lets B run beside the DP instruction, or that forgets the hold cycle, issues early and fails the compare.
- Special-function instructions from several warps queued behind the unit's recovery gap. A wrong gap counter, or a rotation that restarts at warp 0, releases them in the wrong cycle or the wrong order.
- A dependent instruction waiting on its own earlier destination, and a memory-parked warp waiting on a return. A scoreboard that misses a source index, or that unparks on an ordinary writeback, issues before the pulse.
- A long pseudo-random phase that mixes pointer wrap-around at warp 47, refused inputs and interleaved returns.

// File: rtl/wsched_pkg.sv
package wsched_pkg;
    localparam int REG_W = 4;
    localparam int NREG  = 1 << REG_W;

    typedef enum logic [1:0] {
        CLS_ALU = 2'd0,
        CLS_DP  = 2'd1,
        CLS_SFU = 2'd2,
        CLS_MEM = 2'd3
    } op_cls_e;

    typedef struct packed {
        op_cls_e          cls;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] src0;
        logic [REG_W-1:0] src1;
    } instr_t;

    // distance of idx from base going upward with wrap at n
    function automatic int rr_dist(input int idx, input int base, input int n);
        return (idx >= base) ? idx - base : idx + n - base;
    endfunction
endpackage

// File: rtl/wsched_rr_pick.sv
module wsched_rr_pick #(
    parameter int N = 48,
    parameter int W = 6
) (
    input  logic [N-1:0] req,
    input  logic [W-1:0] start,
    output logic         found,
    output logic [W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        // walk downward so the closest requester to start is written last
        for (int i = N - 1; i >= 0; i--) begin
            int j;
            j = int'(start) + i;
            if (j >= N) j = j - N;
            if (req[j]) begin
                found = 1'b1;
                idx   = W'(j);
            end
        end
    end
endmodule

// File: rtl/wsched_score.sv
module wsched_score
    import wsched_pkg::*;
#(
    parameter int N = 48,
    parameter int W = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     set_a_v,
    input  logic [W-1:0]             set_a_w,
    input  logic [REG_W-1:0]         set_a_r,
    input  logic                     set_a_mem,
    input  logic                     set_b_v,
    input  logic [W-1:0]             set_b_w,
    input  logic [REG_W-1:0]         set_b_r,
    input  logic                     set_b_mem,
    input  logic                     wb_v,
    input  logic [W-1:0]             wb_w,
    input  logic [REG_W-1:0]         wb_r,
    input  logic                     ret_v,
    input  logic [W-1:0]             ret_w,
    input  logic [REG_W-1:0]         ret_r,
    output logic [N-1:0][NREG-1:0]   pend,
    output logic [N-1:0]             parked
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend   <= '0;
            parked <= '0;
        end else begin
            if (wb_v) pend[wb_w][wb_r] <= 1'b0;
            if (ret_v) begin
                pend[ret_w][ret_r] <= 1'b0;
                parked[ret_w]      <= 1'b0;
            end
            if (set_a_v) begin
                pend[set_a_w][set_a_r] <= 1'b1;
                if (set_a_mem) parked[set_a_w] <= 1'b1;
            end
            if (set_b_v) begin
                pend[set_b_w][set_b_r] <= 1'b1;
                if (set_b_mem) parked[set_b_w] <= 1'b1;
            end
        end
    end

    // R9
    park_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (set_a_v && set_a_mem && !(ret_v && ret_w == set_a_w)) |=> parked[$past(set_a_w)]);
endmodule

// File: rtl/wsched_top.sv
module wsched_top
    import wsched_pkg::*;
#(
    parameter  int NWARPS  = 48,
    parameter  int SFU_GAP = 8,
    parameter  int DP_HOLD = 2,
    localparam int WID_W   = $clog2(NWARPS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WID_W-1:0] in_warp,
    input  logic [1:0]       in_cls,
    input  logic [REG_W-1:0] in_dst,
    input  logic [REG_W-1:0] in_src0,
    input  logic [REG_W-1:0] in_src1,
    output logic             stall,
    input  logic             wb_valid,
    input  logic [WID_W-1:0] wb_warp,
    input  logic [REG_W-1:0] wb_reg,
    input  logic             mem_valid,
    input  logic [WID_W-1:0] mem_warp,
    input  logic [REG_W-1:0] mem_reg,
    output logic             a_valid,
    output logic [WID_W-1:0] a_warp,
    output logic [1:0]       a_cls,
    output logic [REG_W-1:0] a_dst,
    output logic             b_valid,
    output logic [WID_W-1:0] b_warp,
    output logic [1:0]       b_cls,
    output logic [REG_W-1:0] b_dst
);
    localparam int SCW = $clog2(SFU_GAP + 1);
    localparam int DHW = $clog2(DP_HOLD + 1);

    logic [NWARPS-1:0]           slot_v;
    instr_t                      slot_q [NWARPS];
    logic [NWARPS-1:0][NREG-1:0] pend;
    logic [NWARPS-1:0]           parked;
    logic [SCW-1:0]              sfu_cnt;
    logic [DHW-1:0]              hold_cnt;
    logic [WID_W-1:0]            rr_ptr, next_ptr;
    logic [NWARPS-1:0]           ready, req_a, req_b;
    logic                        a_found, b_found, a_is_dp;
    logic [WID_W-1:0]            a_idx, b_idx;
    instr_t                      a_ins, b_ins;

    // eligibility: slot filled, not parked, no pending operand, no DP hold
    always_comb begin
        for (int w = 0; w < NWARPS; w++) begin
            ready[w] = slot_v[w] && !parked[w] && (hold_cnt == '0)
                       && !pend[w][slot_q[w].src0] && !pend[w][slot_q[w].src1]
                       && !pend[w][slot_q[w].dst];
            req_a[w] = ready[w] && (slot_q[w].cls != CLS_SFU);
        end
    end

    wsched_rr_pick #(.N(NWARPS), .W(WID_W)) pick_a (
        .req(req_a), .start(rr_ptr), .found(a_found), .idx(a_idx));

    assign a_ins   = slot_q[a_idx];
    assign a_is_dp = a_found && (a_ins.cls == CLS_DP);

    always_comb begin
        for (int w = 0; w < NWARPS; w++) begin
            req_b[w] = ready[w] && !a_is_dp
                       && !(a_found && (a_idx == WID_W'(w)))
                       && ((slot_q[w].cls == CLS_ALU) || (slot_q[w].cls == CLS_MEM)
                           || ((slot_q[w].cls == CLS_SFU) && (sfu_cnt == '0)));
        end
    end

    wsched_rr_pick #(.N(NWARPS), .W(WID_W)) pick_b (
        .req(req_b), .start(rr_ptr), .found(b_found), .idx(b_idx));

    assign b_ins = slot_q[b_idx];

    assign a_valid = a_found;
    assign a_warp  = a_idx;
    assign a_cls   = a_ins.cls;
    assign a_dst   = a_ins.dst;
    assign b_valid = b_found;
    assign b_warp  = b_idx;
    assign b_cls   = b_ins.cls;
    assign b_dst   = b_ins.dst;
    assign stall   = in_valid && slot_v[in_warp];

    // pointer goes past the issued warp lying later in rotation order
    always_comb begin
        int da, db, lw;
        da = a_found ? rr_dist(int'(a_idx), int'(rr_ptr), NWARPS) : -1;
        db = b_found ? rr_dist(int'(b_idx), int'(rr_ptr), NWARPS) : -1;
        lw = (db > da) ? int'(b_idx) : int'(a_idx);
        next_ptr = (lw == NWARPS - 1) ? '0 : WID_W'(lw + 1);
    end

    wsched_score #(.N(NWARPS), .W(WID_W)) score (
        .clk(clk), .rst(rst),
        .set_a_v(a_found), .set_a_w(a_idx), .set_a_r(a_ins.dst),
        .set_a_mem(a_ins.cls == CLS_MEM),
        .set_b_v(b_found), .set_b_w(b_idx), .set_b_r(b_ins.dst),
        .set_b_mem(b_ins.cls == CLS_MEM),
        .wb_v(wb_valid), .wb_w(wb_warp), .wb_r(wb_reg),
        .ret_v(mem_valid), .ret_w(mem_warp), .ret_r(mem_reg),
        .pend(pend), .parked(parked));

    always_ff @(posedge clk) begin
        if (in_valid && !slot_v[in_warp])
            slot_q[in_warp] <= '{cls: op_cls_e'(in_cls), dst: in_dst,
                                 src0: in_src0, src1: in_src1};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_v   <= '0;
            sfu_cnt  <= '0;
            hold_cnt <= '0;
            rr_ptr   <= '0;
        end else begin
            if (a_found) slot_v[a_idx] <= 1'b0;
            if (b_found) slot_v[b_idx] <= 1'b0;
            if (in_valid && !slot_v[in_warp]) slot_v[in_warp] <= 1'b1;
            if (b_found && (b_ins.cls == CLS_SFU)) sfu_cnt <= SCW'(SFU_GAP - 1);
            else if (sfu_cnt != '0)                sfu_cnt <= sfu_cnt - 1'b1;
            if (a_is_dp)               hold_cnt <= DHW'(DP_HOLD - 1);
            else if (hold_cnt != '0)   hold_cnt <= hold_cnt - 1'b1;
            if (a_found || b_found) rr_ptr <= next_ptr;
        end
    end

    // independent cycle counter since the last special-function issue
    logic [SCW-1:0] since_sfu;
    always_ff @(posedge clk) begin
        if (rst)                              since_sfu <= SCW'(SFU_GAP);
        else if (b_valid && b_cls == CLS_SFU) since_sfu <= SCW'(1);
        else if (since_sfu < SCW'(SFU_GAP))   since_sfu <= since_sfu + 1'b1;
    end

    // R3
    pair_distinct_chk: assert property (@(posedge clk) disable iff (rst)
        (a_valid && b_valid) |-> (a_warp != b_warp));
    // R5
    a_route_chk: assert property (@(posedge clk) disable iff (rst)
        a_valid |-> (a_cls != CLS_SFU));
    // R5
    b_route_chk: assert property (@(posedge clk) disable iff (rst)
        b_valid |-> (b_cls != CLS_DP));
    // R6
    dp_solo_chk: assert property (@(posedge clk) disable iff (rst)
        (a_valid && a_cls == CLS_DP) |-> !b_valid);
    generate
        if (DP_HOLD >= 2) begin : g_dp_quiet
            // R6
            dp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
                (a_valid && a_cls == CLS_DP) |=> (!a_valid && !b_valid));
        end
    endgenerate
    // R7
    sfu_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (b_valid && b_cls == CLS_SFU) |-> (since_sfu >= SCW'(SFU_GAP)));
    // R8
    dep_clear_chk: assert property (@(posedge clk) disable iff (rst)
        a_valid |-> !pend[a_warp][a_dst]);
    // R9
    parked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (a_valid |-> !parked[a_warp]) and (b_valid |-> !parked[b_warp]));
endmodule

// File: tb/wsched_top_test.sv
module wsched_top_test;
    localparam int NW = 48;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0, wb_valid = 1'b0, mem_valid = 1'b0;
    logic [5:0] in_warp = '0, wb_warp = '0, mem_warp = '0;
    logic [1:0] in_cls = '0;
    logic [3:0] in_dst = '0, in_src0 = '0, in_src1 = '0, wb_reg = '0, mem_reg = '0;
    logic       stall, a_valid, b_valid;
    logic [5:0] a_warp, b_warp;
    logic [1:0] a_cls, b_cls;
    logic [3:0] a_dst, b_dst;

    always #4 clk = ~clk;

    wsched_top uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_warp(in_warp), .in_cls(in_cls),
        .in_dst(in_dst), .in_src0(in_src0), .in_src1(in_src1), .stall(stall),
        .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg),
        .mem_valid(mem_valid), .mem_warp(mem_warp), .mem_reg(mem_reg),
        .a_valid(a_valid), .a_warp(a_warp), .a_cls(a_cls), .a_dst(a_dst),
        .b_valid(b_valid), .b_warp(b_warp), .b_cls(b_cls), .b_dst(b_dst));

    int    total = 0, bad = 0;
    string cur_req = "R1";

    // behavioural reference state
    bit mv[NW];
    int mcls[NW], md[NW], ms0[NW], ms1[NW], mmem[NW];
    bit msb[NW][16];
    bit mpark[NW];
    int msfu = 0, mhold = 0, mptr = 0;
    bit [31:0] lfsr = 32'h1D87_2C45;

    function automatic int rnd(input int n);
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return int'(lfsr[15:0]) % n;
    endfunction

    function automatic bit elig(input int w);
        return mv[w] && !mpark[w] && !msb[w][ms0[w]] && !msb[w][ms1[w]] && !msb[w][md[w]];
    endfunction

    task automatic cyc(input bit iv, input int iw, input int ic, input int idd, input int is0,
                       input int is1, input bit wv, input int ww, input int wr,
                       input bit rv, input int rw, input int rr);
        bit ea, eb, est;
        int wa, wbx, da, db, lw;
        @(negedge clk);
        in_valid = iv; in_warp = 6'(iw); in_cls = 2'(ic); in_dst = 4'(idd);
        in_src0 = 4'(is0); in_src1 = 4'(is1);
        wb_valid = wv; wb_warp = 6'(ww); wb_reg = 4'(wr);
        mem_valid = rv; mem_warp = 6'(rw); mem_reg = 4'(rr);
        #1;
        ea = 0; eb = 0; wa = 0; wbx = 0;
        if (mhold == 0) begin
            for (int i = 0; i < NW; i++) begin
                int w = (mptr + i) % NW;
                if (!ea && elig(w) && mcls[w] != 2) begin ea = 1; wa = w; end
            end
            if (!(ea && mcls[wa] == 1)) begin
                for (int i = 0; i < NW; i++) begin
                    int w = (mptr + i) % NW;
                    if (!eb && elig(w) && !(ea && w == wa) &&
                        (mcls[w] == 0 || mcls[w] == 3 || (mcls[w] == 2 && msfu == 0))) begin
                        eb = 1; wbx = w;
                    end
                end
            end
        end
        est = iv && mv[iw];
        total++;
        if (a_valid !== ea || (ea && (a_warp !== 6'(wa) || a_cls !== 2'(mcls[wa]) ||
                                      a_dst !== 4'(md[wa])))) begin
            bad++;
            $display("FAIL %s sub-block A: actual v=%0b w=%0d c=%0d d=%0d expected v=%0b w=%0d c=%0d d=%0d",
                     cur_req, a_valid, a_warp, a_cls, a_dst, ea, wa, mcls[wa], md[wa]);
        end
        total++;
        if (b_valid !== eb || (eb && (b_warp !== 6'(wbx) || b_cls !== 2'(mcls[wbx]) ||
                                      b_dst !== 4'(md[wbx])))) begin
            bad++;
            $display("FAIL %s sub-block B: actual v=%0b w=%0d c=%0d d=%0d expected v=%0b w=%0d c=%0d d=%0d",
                     cur_req, b_valid, b_warp, b_cls, b_dst, eb, wbx, mcls[wbx], md[wbx]);
        end
        total++;
        if (stall !== est) begin
            bad++;
            $display("FAIL R2 stall: actual %0b expected %0b", stall, est);
        end
        // advance the reference to the next edge
        if (wv) msb[ww][wr] = 0;
        if (rv) begin msb[rw][rr] = 0; mpark[rw] = 0; end
        if (ea) begin
            msb[wa][md[wa]] = 1; mv[wa] = 0;
            if (mcls[wa] == 3) begin mpark[wa] = 1; mmem[wa] = md[wa]; end
        end
        if (eb) begin
            msb[wbx][md[wbx]] = 1; mv[wbx] = 0;
            if (mcls[wbx] == 3) begin mpark[wbx] = 1; mmem[wbx] = md[wbx]; end
        end
        if (eb && mcls[wbx] == 2) msfu = 7;
        else if (msfu > 0) msfu--;
        if (ea && mcls[wa] == 1) mhold = 1;
        else if (mhold > 0) mhold--;
        if (ea || eb) begin
            da = ea ? (wa - mptr + NW) % NW : -1;
            db = eb ? (wbx - mptr + NW) % NW : -1;
            lw = (db > da) ? wbx : wa;
            mptr = (lw + 1) % NW;
        end
        if (iv && !est) begin
            mv[iw] = 1; mcls[iw] = ic; md[iw] = idd; ms0[iw] = is0; ms1[iw] = is1;
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic put(input int w, input int c, input int d, input int s0, input int s1);
        cyc(1, w, c, d, s0, s1, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL R1 watchdog: actual hung expected finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        cur_req = "R1"; idle(2);
        // R2: refused while slot full, retried later
        cur_req = "R2";
        put(5, 0, 1, 0, 0); put(5, 0, 2, 0, 0); put(5, 0, 2, 0, 0); idle(2);
        // R6 then R3: DP solo plus hold, then two ALU warps together
        cur_req = "R6";
        put(2, 1, 5, 0, 0); put(3, 0, 1, 0, 0); put(4, 0, 1, 0, 0);
        cur_req = "R3"; idle(3);
        // R7 and R4: special-function queue released one per gap in rotation order
        cur_req = "R7";
        for (int w = 30; w < 36; w++) put(w, 2, 2, 9, 9);
        cur_req = "R4";
        put(40, 0, 3, 0, 0); put(41, 3, 3, 0, 0); put(20, 0, 3, 0, 0);
        idle(50);
        // R5: DP and SFU routing together
        cur_req = "R5";
        put(11, 2, 6, 0, 0); put(12, 1, 6, 0, 0); idle(4);
        // R8: dependent instruction waits for writeback
        cur_req = "R8";
        put(8, 0, 3, 0, 0); idle(1); put(8, 0, 6, 3, 0); idle(3);
        cyc(0, 0, 0, 0, 0, 0, 1, 8, 3, 0, 0, 0); idle(2);
        // R9: parked warp waits for memory return
        cur_req = "R9";
        put(9, 3, 4, 0, 0); idle(1); put(9, 0, 7, 1, 2); idle(4);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 9, 4); idle(2);
        // mixed pseudo-random traffic
        cur_req = "R3";
        for (int k = 0; k < 4000; k++) begin
            bit iv, wv, rv, got;
            int ww, wr, st;
            iv = (rnd(4) != 0);
            wv = 0; rv = 0; ww = 0; wr = 0; got = 0;
            if (rnd(2) == 0) begin
                st = rnd(NW);
                for (int i = 0; i < NW; i++) begin
                    int w = (st + i) % NW;
                    for (int r = 0; r < 16; r++) begin
                        if (!got && msb[w][r]) begin got = 1; ww = w; wr = r; end
                    end
                end
                if (got) begin
                    if (mpark[ww] && wr == mmem[ww]) rv = 1; else wv = 1;
                end
            end
            cyc(iv, rnd(NW), rnd(4), rnd(16), rnd(16), rnd(16), wv, ww, wr, rv, ww, wr);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule